// File: doc/BRIEF.md
# Permuted-Order Serial Lane Transmitter

This block turns a wide parallel word into several narrow serial streams. A word of `NP` bits comes in over a valid/ready handshake. It is cut into `NS` equal slices of `N = NP/NS` bits, and each slice leaves on its own single wire, one bit per clock. The wire does not have to send bit 0 first. Each lane holds a small programmable table that lists, for each transmit slot, which bit of the slice is sent in that slot. Software loads a bit order that places bits which usually agree next to each other. The wire then toggles less, which cuts its switching activity.

A mode input selects, for each word, either the table order or plain positional order (slot k carries bit k). The positional order is the baseline that savings are measured against. Every lane counts the value changes on its wire in a saturating counter. The bit order is treated as a closed loop: the step from the last bit of one word to the first bit of the next word also counts. So the totals show the real activity on the wire, and two orders can be compared by running the same traffic through each.

All lanes run in lockstep. A new word is taken only in the last slot of the current word, or when the block is idle. Words sent back to back therefore follow each other with no gap. A marker output is high in the slot that carries the first bit of each word.

Top module: `rps_link_tx`

## Requirements
- R1: Lane l transmits only the slice `in_word[l*N +: N]` of the accepted word; no lane ever emits a bit of another lane's slice.
- R2: With `mode_perm`=1 at acceptance, in transmit slot k (k = 0 first) lane l drives slice bit `table[l][k]`, where the table entry is a bit index 0..N-1. After reset every entry holds its own slot number.
- R3: With `mode_perm`=0 at acceptance, slot k carries slice bit k whatever the table holds. The mode is captured at acceptance, so later changes of `mode_perm` do not affect a word already being sent.
- R4: `in_ready` is 1 while idle and in the last slot of a word, and 0 in the other N-1 slots. A word accepted in the last slot starts in the next cycle, with no idle bit between words.
- R5: `ser_start` is 1 exactly in the cycle that carries slot 0 of each word, and 0 otherwise.
- R6: While no word is in transmission, every wire keeps its last driven value and the counters do not change.
- R7: A lane's counter increments by one in each cycle in which its transmitted bit differs from the previous wire value. This includes the step from the last bit of one word to the first bit of the next, and the first bit after reset compared with the reset wire value 0.
- R8: A counter that has reached its all-ones value (2^CNT_W - 1) stays there.
- R9: When `cnt_clr` is 1 at a clock edge, every counter is 0 after that edge, even if a transition occurs in the same cycle.
- R10: A table write (`cfg_we`, lane `cfg_lane`, slot `cfg_slot`, bit index `cfg_pos`) made while no word is in transmission is stored and does not raise `cfg_err`. If it comes in the same cycle as a word's acceptance, it already applies to that word.
- R11: A table write made while a word is in transmission, including its last slot, is discarded, and `cfg_err` is 1 in the following cycle.
- R12: After reset all wires are 0, `ser_start` and `cfg_err` are 0, `in_ready` is 1 and every counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Parallel word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | NP | Parallel word, lane l owns bits l*N +: N |
| mode_perm | input | 1 | 1 = table order, 0 = positional order; sampled at acceptance |
| cfg_we | input | 1 | Table write strobe |
| cfg_lane | input | LW | Lane addressed by the write |
| cfg_slot | input | IW | Transmit slot being written |
| cfg_pos | input | IW | Slice bit index sent in that slot |
| cfg_err | output | 1 | Pulse: previous cycle's write was refused |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| ser_out | output | NS | One serial wire per lane |
| ser_start | output | 1 | Marks the slot-0 bit of each word |
| toggle_cnt | output | NS*CNT_W | Per-lane transition counters, lane l at l*CNT_W +: CNT_W |

## Verification
The main case is a table write that arrives in the same cycle as another event. A write in the cycle in which an idle block takes a word must already steer that word's first bit. A write in a word's last slot looks harmless because `in_ready` is high there, yet it must be refused and flagged. The bench creates both cases on purpose and then sends a probing word. It compares the stream against a reference computed from the bench's own copy of the table, so a write that lands when it should not, or is lost when it should land, shows up in the stream. A second overlap, a counter clear in a cycle with a wire transition, is produced by holding the clear across random traffic. The per-cycle software count then decides whether the clear won.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;

   // Order used for one word; captured when the word is accepted.
   typedef enum logic {
      ORD_POSITIONAL = 1'b0,
      ORD_TABLE      = 1'b1
   } ord_mode_t;

   // Width of an index into n items, never below one bit.
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rps_ctrl.sv
`timescale 1ns/1ps
// Shared slot sequencer: all lanes walk the same slot in lockstep.
module rps_ctrl
   import rps_pkg::*;
#(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  ord_mode_t     mode_in,
   output logic          in_ready,
   output logic          load,
   output logic          busy,
   output logic [IW-1:0] slot,
   output ord_mode_t     word_mode,
   output logic          start
);

   localparam logic [IW-1:0] LAST_SLOT = IW'(N - 1);

   logic          busy_q;
   logic [IW-1:0] slot_q;
   ord_mode_t     mode_q;
   logic          at_last;

   assign at_last  = (slot_q == LAST_SLOT);
   assign in_ready = !busy_q || at_last;
   assign load     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         slot_q <= '0;
         mode_q <= ORD_POSITIONAL;
      end else if (load) begin
         busy_q <= 1'b1;
         slot_q <= '0;
         mode_q <= mode_in;
      end else if (busy_q) begin
         if (at_last) begin
            busy_q <= 1'b0;
            slot_q <= '0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign slot      = slot_q;
   assign word_mode = mode_q;
   assign start     = busy_q && (slot_q == '0);

endmodule

// File: rtl/rps_perm_table.sv
`timescale 1ns/1ps
// Per-lane slot-to-bit lookup. Variant chosen at elaboration.
module rps_perm_table #(
   parameter int N         = 32,
   parameter int IW        = 5,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] wslot,
   input  logic [IW-1:0] wpos,
   input  logic [IW-1:0] rslot,
   output logic [IW-1:0] rpos
);

   generate
      if (USE_TABLE) begin : g_store
         logic [IW-1:0] ent_q [N];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < N; i++) ent_q[i] <= IW'(i);
            end else if (we) begin
               ent_q[wslot] <= wpos;
            end
         end

         assign rpos = ent_q[rslot];
      end else begin : g_fixed
         logic unused_bits;
         assign unused_bits = ^{clk, rst_n, we, wslot, wpos};
         assign rpos        = rslot;
      end
   endgenerate

endmodule

// File: rtl/rps_lane.sv
`timescale 1ns/1ps
// One serial lane: word hold register, bit select, wire hold, toggle counter.
module rps_lane
   import rps_pkg::*;
#(
   parameter int N         = 32,
   parameter int IW        = 5,
   parameter int CNT_W     = 32,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [N-1:0]     slice_in,
   input  logic             busy,
   input  logic [IW-1:0]    slot,
   input  ord_mode_t        word_mode,
   input  logic             tbl_we,
   input  logic [IW-1:0]    tbl_slot,
   input  logic [IW-1:0]    tbl_pos,
   input  logic             cnt_clr,
   output logic             ser_bit,
   output logic [CNT_W-1:0] tcount
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [N-1:0]     hold_q;
   logic [IW-1:0]    tbl_rd;
   logic [IW-1:0]    pick;
   logic             cur_bit;
   logic             wire_q;
   logic             flip;
   logic [CNT_W-1:0] cnt_q;

   rps_perm_table #(
      .N         (N),
      .IW        (IW),
      .USE_TABLE (USE_TABLE)
   ) i_table (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .wslot (tbl_slot),
      .wpos  (tbl_pos),
      .rslot (slot),
      .rpos  (tbl_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= '0;
      else if (load) hold_q <= slice_in;
   end

   assign pick    = (word_mode == ORD_TABLE) ? tbl_rd : slot;
   assign cur_bit = hold_q[pick];

   // Last value driven on the wire; only moves while a word is out.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wire_q <= 1'b0;
      else if (busy) wire_q <= cur_bit;
   end

   assign ser_bit = busy ? cur_bit : wire_q;
   assign flip    = busy && (cur_bit != wire_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (cnt_clr)                  cnt_q <= '0;
      else if (flip && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign tcount = cnt_q;

endmodule

// File: rtl/rps_link_tx.sv
`timescale 1ns/1ps
// Top: parallel word in, NS permuted serial lanes out.
module rps_link_tx
   import rps_pkg::*;
#(
   parameter int NP        = 64,
   parameter int NS        = 2,
   parameter int CNT_W     = 32,
   parameter bit USE_TABLE = 1'b1,
   localparam int N        = NP / NS,
   localparam int IW       = idx_w(N),
   localparam int LW       = idx_w(NS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [NP-1:0]       in_word,
   input  logic                mode_perm,
   input  logic                cfg_we,
   input  logic [LW-1:0]       cfg_lane,
   input  logic [IW-1:0]       cfg_slot,
   input  logic [IW-1:0]       cfg_pos,
   output logic                cfg_err,
   input  logic                cnt_clr,
   output logic [NS-1:0]       ser_out,
   output logic                ser_start,
   output logic [NS*CNT_W-1:0] toggle_cnt
);

   // Elaboration-time parameter checks.
   generate
      if (NP % NS != 0) begin : g_bad_split
         $error("NP must be a multiple of NS");
      end
      if (N < 2) begin : g_bad_n
         $error("each lane needs at least two bits");
      end
      if ((1 << IW) != N) begin : g_bad_pow
         $error("lane width must be a power of two");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("counter width must be positive");
      end
   endgenerate

   ord_mode_t     mode_in;
   ord_mode_t     word_mode;
   logic          load;
   logic          busy;
   logic [IW-1:0] slot;
   logic          cfg_ok;
   logic          cfg_err_q;

   assign mode_in = mode_perm ? ORD_TABLE : ORD_POSITIONAL;

   rps_ctrl #(
      .N  (N),
      .IW (IW)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .mode_in   (mode_in),
      .in_ready  (in_ready),
      .load      (load),
      .busy      (busy),
      .slot      (slot),
      .word_mode (word_mode),
      .start     (ser_start)
   );

   // Table writes land only while no word is on the wires.
   assign cfg_ok = cfg_we && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err_q <= 1'b0;
      else        cfg_err_q <= cfg_we && busy;
   end
   assign cfg_err = cfg_err_q;

   generate
      for (genvar l = 0; l < NS; l++) begin : g_lane
         logic lane_we;
         assign lane_we = cfg_ok && (cfg_lane == LW'(l));

         rps_lane #(
            .N         (N),
            .IW        (IW),
            .CNT_W     (CNT_W),
            .USE_TABLE (USE_TABLE)
         ) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .slice_in  (in_word[l*N +: N]),
            .busy      (busy),
            .slot      (slot),
            .word_mode (word_mode),
            .tbl_we    (lane_we),
            .tbl_slot  (cfg_slot),
            .tbl_pos   (cfg_pos),
            .cnt_clr   (cnt_clr),
            .ser_bit   (ser_out[l]),
            .tcount    (toggle_cnt[l*CNT_W +: CNT_W])
         );
      end
   endgenerate

endmodule

// File: rtl/rps_link_tx_chk.sv
`timescale 1ns/1ps
module rps_link_tx_chk #(
   parameter int N     = 32,
   parameter int NS    = 2,
   parameter int CNT_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                cfg_we,
   input logic                cfg_err,
   input logic                busy,
   input logic                ser_start,
   input logic [NS-1:0]       ser_out,
   input logic                cnt_clr,
   input logic [NS*CNT_W-1:0] toggle_cnt
);

   // R4
   accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> ser_start);

   // R4
   start_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_start |-> !in_ready);

   // R5
   start_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_start |-> busy);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !in_valid |=> $stable(ser_out));

   // R6
   idle_nocount_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !cnt_clr |=> $stable(toggle_cnt));

   // R8
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> toggle_cnt[CNT_W-1:0] >= $past(toggle_cnt[CNT_W-1:0]));

   // R9
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> toggle_cnt == '0);

   // R10
   idle_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !busy |=> !cfg_err);

   // R11
   busy_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && busy |=> cfg_err);

endmodule

bind rps_link_tx rps_link_tx_chk #(
   .N     (N),
   .NS    (NS),
   .CNT_W (CNT_W)
) i_rps_link_tx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .cfg_we     (cfg_we),
   .cfg_err    (cfg_err),
   .busy       (busy),
   .ser_start  (ser_start),
   .ser_out    (ser_out),
   .cnt_clr    (cnt_clr),
   .toggle_cnt (toggle_cnt)
);

// File: tb/test_rps_link_tx.sv
`timescale 1ns/1ps
module test_rps_link_tx;

   localparam int NP    = 32;
   localparam int NS    = 4;
   localparam int CNT_W = 6;
   localparam int N     = NP / NS;
   localparam int IW    = 3;
   localparam int LW    = 2;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic                in_ready;
   logic [NP-1:0]       in_word = '0;
   logic                mode_perm = 1'b0;
   logic                cfg_we = 1'b0;
   logic [LW-1:0]       cfg_lane = '0;
   logic [IW-1:0]       cfg_slot = '0;
   logic [IW-1:0]       cfg_pos = '0;
   logic                cfg_err;
   logic                cnt_clr = 1'b0;
   logic [NS-1:0]       ser_out;
   logic                ser_start;
   logic [NS*CNT_W-1:0] toggle_cnt;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [IW-1:0]       tbl [NS][N];
   logic [NS*N-1:0]     exp_q [$];

   always #5 clk = ~clk;

   rps_link_tx #(
      .NP    (NP),
      .NS    (NS),
      .CNT_W (CNT_W)
   ) i_rps_link_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_word    (in_word),
      .mode_perm  (mode_perm),
      .cfg_we     (cfg_we),
      .cfg_lane   (cfg_lane),
      .cfg_slot   (cfg_slot),
      .cfg_pos    (cfg_pos),
      .cfg_err    (cfg_err),
      .cnt_clr    (cnt_clr),
      .ser_out    (ser_out),
      .ser_start  (ser_start),
      .toggle_cnt (toggle_cnt)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Expected per-lane stream, bit l*N+k = slot k of lane l (R1, R2, R3).
   function automatic logic [NS*N-1:0] model_stream(input logic [NP-1:0] w, input logic m);
      logic [NS*N-1:0] r;
      for (int l = 0; l < NS; l++)
         for (int k = 0; k < N; k++)
            r[l*N+k] = w[l*N + (m ? int'(tbl[l][k]) : k)];
      return r;
   endfunction

   // Driver: starts and ends just after a rising edge.
   task automatic send_word(input logic [NP-1:0] w, input logic m);
      in_valid  = 1'b1;
      in_word   = w;
      mode_perm = m;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      exp_q.push_back(model_stream(w, m));
      @(posedge clk); #1;
      in_valid  = 1'b0;
      mode_perm = ~m;   // must not touch the word in flight (R3)
   endtask

   task automatic write_tbl(input int l, input int s, input int p, input bit ok, input string req);
      cfg_we   = 1'b1;
      cfg_lane = LW'(l);
      cfg_slot = IW'(s);
      cfg_pos  = IW'(p);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      chk(req, "cfg_err after write", longint'(cfg_err), longint'(!ok));
      if (ok) tbl[l][s] = IW'(p);
   endtask

   task automatic go_idle();
      repeat (N + 2) @(posedge clk);
      #1;
   endtask

   // Monitor / scoreboard.
   int              k_m = N;
   logic [NS*N-1:0] cur_m;
   logic [NS-1:0]   wire_m = '0;
   int              cnt_m [NS];

   always @(negedge clk) begin
      if (rst_n) begin
         for (int l = 0; l < NS; l++)
            chk("R7", $sformatf("lane %0d count", l),
                longint'(toggle_cnt[l*CNT_W +: CNT_W]), longint'(cnt_m[l]));
         if (ser_start) begin
            chk("R4", "start only after last slot", longint'(k_m >= N), 1);
            if (exp_q.size() == 0) begin
               chk("R5", "start with no word pending", 1, 0);
               k_m = N;
            end else begin
               cur_m = exp_q.pop_front();
               k_m = 0;
            end
         end
         if (k_m < N) begin
            for (int l = 0; l < NS; l++) begin
               logic eb;
               eb = cur_m[l*N + k_m];
               chk("R2", $sformatf("lane %0d slot %0d bit", l, k_m),
                   longint'(ser_out[l]), longint'(eb));
               if (cnt_clr) cnt_m[l] = 0;
               else if (eb != wire_m[l] && cnt_m[l] < CMAX) cnt_m[l]++;
               wire_m[l] = eb;
            end
            chk("R4", $sformatf("ready in slot %0d", k_m),
                longint'(in_ready), longint'(k_m == N - 1));
            chk("R5", "start marker", longint'(ser_start), longint'(k_m == 0));
            k_m++;
         end else begin
            chk("R6", "idle wire hold", longint'(ser_out), longint'(wire_m));
            chk("R6", "idle ready", longint'(in_ready), 1);
            if (cnt_clr) for (int l = 0; l < NS; l++) cnt_m[l] = 0;
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int l = 0; l < NS; l++) begin
         cnt_m[l] = 0;
         for (int k = 0; k < N; k++) tbl[l][k] = IW'(k);
      end
      repeat (3) @(posedge clk);
      #1;
      // R12 reset state
      chk("R12", "wires", longint'(ser_out), 0);
      chk("R12", "start", longint'(ser_start), 0);
      chk("R12", "ready", longint'(in_ready), 1);
      chk("R12", "cfg_err", longint'(cfg_err), 0);
      chk("R12", "counters", longint'(toggle_cnt), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 R3: positional baseline, structured patterns, back to back
      send_word(32'h0000_0000, 1'b0);
      send_word(32'hFFFF_FFFF, 1'b0);
      send_word(32'hA5C3_0F81, 1'b0);
      send_word(32'h0000_FF00, 1'b1);   // identity table after reset (R2)
      go_idle();

      // R10: program an odd-stride order per lane while idle
      for (int l = 0; l < NS; l++)
         for (int k = 0; k < N; k++)
            write_tbl(l, k, (k * 3 + l) % N, 1'b1, "R10");

      // R2: permuted order, random back-to-back words
      for (int i = 0; i < 8; i++) send_word($urandom, 1'b1);
      // R3: table loaded but positional mode selected
      for (int i = 0; i < 4; i++) send_word($urandom, 1'b0);
      go_idle();

      // R11: writes in slot 0 and in the last slot are refused
      send_word(32'h1357_9BDF, 1'b1);
      write_tbl(0, 0, 7, 1'b0, "R11");
      repeat (N - 2) @(posedge clk);
      #1;
      write_tbl(1, 2, 0, 1'b0, "R11");
      send_word(32'hF0E1_D2C3, 1'b1);   // stream proves table untouched
      go_idle();

      // R10: write in the same cycle as acceptance applies to that word
      cfg_we    = 1'b1;
      cfg_lane  = 2'd2;
      cfg_slot  = 3'd0;
      cfg_pos   = 3'd5;
      tbl[2][0] = 3'd5;
      in_valid  = 1'b1;
      in_word   = 32'h0020_0000;
      mode_perm = 1'b1;
      @(negedge clk);
      chk("R10", "ready for combined cycle", longint'(in_ready), 1);
      exp_q.push_back(model_stream(in_word, 1'b1));
      @(posedge clk); #1;
      cfg_we   = 1'b0;
      in_valid = 1'b0;
      chk("R10", "cfg_err combined cycle", longint'(cfg_err), 0);
      go_idle();

      // R8: saturation with alternating pattern
      cnt_clr = 1'b1;
      @(posedge clk); #1;
      cnt_clr = 1'b0;
      for (int i = 0; i < 11; i++) send_word(32'h5555_5555, 1'b0);
      go_idle();
      chk("R8", "lane 0 saturated", longint'(toggle_cnt[CNT_W-1:0]), CMAX);

      // R9: clear held across random traffic, colliding with transitions
      for (int i = 0; i < 30; i++) begin
         cnt_clr = ($urandom % 5 == 0);
         send_word($urandom, 1'($urandom));
         cnt_clr = 1'b0;
         if ($urandom % 4 == 0) go_idle();
      end
      go_idle();
      chk("R6", "scoreboard drained", longint'(exp_q.size()), 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule